// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block stores received frames in a circular region of local memory made of 256-byte pages. The ring runs from a programmable first page up to, but not including, a programmable end page. A current-page pointer marks where the next frame goes. A host-owned boundary pointer marks the oldest page the host has not yet released. Frames arrive as a byte stream with start and end markers and error flags. Each byte is written at once through a byte-addressed memory write port. Data starts four bytes into the frame's first page.

When the last byte has arrived, the block decides what to do with the frame. A frame that passes the checks gets a four-byte header written into the first bytes of its first page. The header holds a status byte, the page where the next frame will start, and a 16-bit count. After the header is written, the current pointer moves on. A dropped frame leaves the current pointer where it was, so its partial data is overwritten later. If a frame would run into the boundary page, it is dropped, and a halt flag is raised. The flag stays up until the host moves the boundary pointer.

The host sets the four page pointers through a small register port. The source must keep the byte stream idle for at least four cycles after each end-of-frame byte.

Top module: `rx_page_ring`

## Requirements
- R1: Writes go only to pages p with first <= p < end. When a page increment reaches the end page it wraps to the first page. This applies both to data writes and to the next-page value stored in the header.
- R2: A byte accepted on a rising edge is written one cycle later. The write address is page*256 + offset. The first byte of a frame goes to offset 4 of the current page, and later bytes follow at consecutive addresses.
- R3: For a stored frame of N bytes, the header is written at offsets 0..3 of the frame's first page, in the four cycles after the end-of-frame byte.
  - Offset 0 holds the status byte: bit0 is set when the frame has no error, bit1 is the CRC error, bit2 is the alignment error, and the other bits are 0.
  - Offset 1 holds the next page.
  - Offsets 2 and 3 hold the low and high bytes of N+4.
  - `frm_stored` pulses, and the current page takes the next-page value, in the cycle of the fourth header write.
- R4: A frame is dropped if its data would enter the boundary page, or if its next-page value equals the boundary page. Data bytes stop once the boundary page is reached. `frm_overwrite` and `frm_missed` pulse together in the cycle after the end-of-frame edge.
- R5: When `cfg_monitor` is set at frame start, nothing of the frame is written, and `frm_missed` pulses in the cycle after the end-of-frame edge.
- R6: A frame shorter than 64 bytes is dropped with a `frm_discard` pulse unless `cfg_accept_runt` is set, in which case it is stored normally.
- R7: A frame with a CRC or alignment error is dropped with a `frm_discard` pulse unless `cfg_save_errored` is set, in which case it is stored with its error bits in the status byte.
- R8: `ring_halt` rises one cycle after an overwrite pulse. It clears when the host writes a boundary value different from the one held. It stays set if the host writes the same value again.
- R9: A dropped frame, whether discarded, overwritten or monitored, leaves the current page unchanged.
- R10: Register addresses are: 0 for the first page, 1 for the end page, 2 for the current page and 3 for the boundary page. Writes take effect on the clock edge. `reg_rdata` shows the addressed register in the same cycle. After reset the four registers hold 0x40, 0x80, 0x40 and 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | CRC error, valid with in_eof |
| in_align_err | input | 1 | Alignment error, valid with in_eof |
| cfg_accept_runt | input | 1 | Keep frames shorter than 64 bytes |
| cfg_save_errored | input | 1 | Keep frames with errors |
| cfg_monitor | input | 1 | Check only, store nothing |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | PG_W | Register write value |
| reg_rdata | output | PG_W | Selected register value |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | PG_W+8 | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| frm_stored | output | 1 | Frame stored pulse |
| frm_missed | output | 1 | Frame missed pulse |
| frm_overwrite | output | 1 | Boundary overrun pulse |
| frm_discard | output | 1 | Frame discarded pulse |
| ring_halt | output | 1 | Overrun halt flag |

## Verification
The timing the bench relies on is as follows:
- A data write appears one cycle after the edge that takes its byte.
- Outcome pulses appear in that same cycle for the end-of-frame byte.
- Header writes come one to four cycles after the end-of-frame edge, with the stored pulse and the current-page update on the fourth.
- The halt flag follows an overwrite pulse one cycle later.

The bench model computes each frame's write addresses with its own page arithmetic and stamps each expected write with the cycle number in which it is due. On every falling edge it compares the write port against the head of that queue and the four pulses against their due cycles. An early, late, missing or extra write or pulse is therefore reported as a failure. Register values are read in the same cycle they are selected, once each frame has settled.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int OFF_W     = 8;   // byte offset within a 256-byte page
  localparam int CNT_W     = 16;  // header count field width
  localparam int DATA_OFF  = 4;   // data starts after the header
  localparam int ST_GOOD   = 0;
  localparam int ST_CRC    = 1;
  localparam int ST_ALIGN  = 2;
  localparam logic [1:0] RA_START = 2'd0;
  localparam logic [1:0] RA_STOP  = 2'd1;
  localparam logic [1:0] RA_CUR   = 2'd2;
  localparam logic [1:0] RA_BND   = 2'd3;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int PG_W = 8,
  parameter logic [PG_W-1:0] START_DEF = 8'h40,
  parameter logic [PG_W-1:0] STOP_DEF  = 8'h80
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [PG_W-1:0] reg_wdata,
  output logic [PG_W-1:0] reg_rdata,
  input  logic            cur_load,
  input  logic [PG_W-1:0] cur_next,
  input  logic            ovw_evt,
  output logic [PG_W-1:0] start_pg,
  output logic [PG_W-1:0] stop_pg,
  output logic [PG_W-1:0] cur_pg,
  output logic [PG_W-1:0] bnd_pg,
  output logic            halt
);
  localparam logic [PG_W-1:0] BND_DEF = STOP_DEF - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pg <= START_DEF;
      stop_pg  <= STOP_DEF;
      cur_pg   <= START_DEF;
      bnd_pg   <= BND_DEF;
      halt     <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_START) start_pg <= reg_wdata;
      if (reg_we && reg_addr == RA_STOP)  stop_pg  <= reg_wdata;
      if (cur_load)                       cur_pg   <= cur_next;
      else if (reg_we && reg_addr == RA_CUR) cur_pg <= reg_wdata;
      if (reg_we && reg_addr == RA_BND)   bnd_pg   <= reg_wdata;
      if (ovw_evt) halt <= 1'b1;
      else if (reg_we && reg_addr == RA_BND && reg_wdata != bnd_pg) halt <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_START: reg_rdata = start_pg;
      RA_STOP:  reg_rdata = stop_pg;
      RA_CUR:   reg_rdata = cur_pg;
      default:  reg_rdata = bnd_pg;
    endcase
  end

  AST_HALT_ON_OVW: assert property (@(posedge clk) disable iff (rst)
    ovw_evt |=> halt);  // R8
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cur_load && !(reg_we && reg_addr == RA_CUR)) |=> $stable(cur_pg));  // R9
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int PG_W    = 8,
  parameter int MIN_LEN = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  input  logic                  in_sof,
  input  logic                  in_eof,
  input  logic                  in_crc_err,
  input  logic                  in_align_err,
  input  logic                  cfg_accept_runt,
  input  logic                  cfg_save_errored,
  input  logic                  cfg_monitor,
  input  logic [PG_W-1:0]       start_pg,
  input  logic [PG_W-1:0]       stop_pg,
  input  logic [PG_W-1:0]       cur_pg,
  input  logic [PG_W-1:0]       bnd_pg,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  cur_load,
  output logic [PG_W-1:0]       cur_next,
  output logic                  done_ok,
  output logic                  frm_missed,
  output logic                  frm_ovw,
  output logic                  frm_discard
);
  function automatic logic [PG_W-1:0] pg_inc(input logic [PG_W-1:0] p,
                                             input logic [PG_W-1:0] s,
                                             input logic [PG_W-1:0] e);
    logic [PG_W-1:0] q;
    q = p + 1'b1;
    return (q == e) ? s : q;
  endfunction

  logic [PG_W-1:0]  wp_pg, first_pg, hdr_next;
  logic [OFF_W-1:0] wp_off;
  logic [CNT_W-1:0] cnt, hdr_len;
  logic [7:0]       hdr_status;
  logic [1:0]       hdr_idx;
  logic             hdr_busy, blk, mon_lat;

  logic [PG_W-1:0]  b_pg, a_pg, nxt_c;
  logic [OFF_W-1:0] b_off, a_off;
  logic [CNT_W-1:0] cnt_c;
  logic             blk_c, mon_c, enter_bnd, ovf_end, bad, short_c, keep;
  logic [7:0]       st_c;

  always_comb begin
    b_pg      = in_sof ? cur_pg : wp_pg;
    b_off     = in_sof ? OFF_W'(DATA_OFF) : wp_off;
    blk_c     = in_sof ? 1'b0 : blk;
    mon_c     = in_sof ? cfg_monitor : mon_lat;
    cnt_c     = in_sof ? CNT_W'(1) : cnt + 1'b1;
    a_off     = b_off + 1'b1;
    a_pg      = (a_off == '0) ? pg_inc(b_pg, start_pg, stop_pg) : b_pg;
    enter_bnd = (a_off == '0) && (a_pg == bnd_pg);
    nxt_c     = (a_off == '0) ? a_pg : pg_inc(a_pg, start_pg, stop_pg);
    ovf_end   = blk_c || enter_bnd || (nxt_c == bnd_pg);
    bad       = in_crc_err || in_align_err;
    short_c   = cnt_c < CNT_W'(MIN_LEN);
    keep      = (!short_c || cfg_accept_runt) && (!bad || cfg_save_errored);
    st_c            = '0;
    st_c[ST_GOOD]   = !bad;
    st_c[ST_CRC]    = in_crc_err;
    st_c[ST_ALIGN]  = in_align_err;
  end

  assign cur_load = hdr_busy && (hdr_idx == 2'd3);
  assign cur_next = hdr_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      done_ok <= 1'b0; frm_missed <= 1'b0; frm_ovw <= 1'b0; frm_discard <= 1'b0;
      wp_pg <= '0; wp_off <= '0; first_pg <= '0; cnt <= '0;
      blk <= 1'b0; mon_lat <= 1'b0; hdr_busy <= 1'b0; hdr_idx <= '0;
      hdr_status <= '0; hdr_next <= '0; hdr_len <= '0;
    end else begin
      mem_we <= 1'b0; done_ok <= 1'b0; frm_missed <= 1'b0;
      frm_ovw <= 1'b0; frm_discard <= 1'b0;
      if (hdr_busy) begin
        mem_we   <= 1'b1;
        mem_addr <= {first_pg, OFF_W'(hdr_idx)};
        case (hdr_idx)
          2'd0:    mem_wdata <= hdr_status;
          2'd1:    mem_wdata <= 8'(hdr_next);
          2'd2:    mem_wdata <= hdr_len[7:0];
          default: mem_wdata <= hdr_len[15:8];
        endcase
        hdr_idx <= hdr_idx + 1'b1;
        if (hdr_idx == 2'd3) begin
          hdr_busy <= 1'b0;
          done_ok  <= 1'b1;
        end
      end else if (in_valid) begin
        if (!mon_c && !blk_c) begin
          mem_we    <= 1'b1;
          mem_addr  <= {b_pg, b_off};
          mem_wdata <= in_data;
        end
        wp_pg   <= a_pg;
        wp_off  <= a_off;
        cnt     <= cnt_c;
        mon_lat <= mon_c;
        blk     <= blk_c || enter_bnd;
        if (in_sof) first_pg <= cur_pg;
        if (in_eof) begin
          if (mon_c) begin
            frm_missed <= 1'b1;
          end else if (ovf_end) begin
            frm_missed <= 1'b1;
            frm_ovw    <= 1'b1;
          end else if (!keep) begin
            frm_discard <= 1'b1;
          end else begin
            hdr_busy   <= 1'b1;
            hdr_idx    <= '0;
            hdr_status <= st_c;
            hdr_next   <= nxt_c;
            hdr_len    <= cnt_c + CNT_W'(DATA_OFF);
          end
        end
      end
    end
  end

  AST_WR_IN_RING: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[PG_W+OFF_W-1:OFF_W] >= start_pg &&
                mem_addr[PG_W+OFF_W-1:OFF_W] <  stop_pg));  // R1
  AST_MON_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mon_lat);  // R5
  AST_QUIET_IN_HDR: assert property (@(posedge clk) disable iff (rst)
    hdr_busy |-> !in_valid);  // R3
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_ok, frm_missed, frm_discard}));  // R6
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
  import rx_ring_pkg::*;
#(
  parameter int PG_W    = 8,
  parameter int MIN_LEN = 64,
  parameter logic [PG_W-1:0] START_DEF = 8'h40,
  parameter logic [PG_W-1:0] STOP_DEF  = 8'h80
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  input  logic                  in_sof,
  input  logic                  in_eof,
  input  logic                  in_crc_err,
  input  logic                  in_align_err,
  input  logic                  cfg_accept_runt,
  input  logic                  cfg_save_errored,
  input  logic                  cfg_monitor,
  input  logic                  reg_we,
  input  logic [1:0]            reg_addr,
  input  logic [PG_W-1:0]       reg_wdata,
  output logic [PG_W-1:0]       reg_rdata,
  output logic                  mem_we,
  output logic [PG_W+OFF_W-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  output logic                  frm_stored,
  output logic                  frm_missed,
  output logic                  frm_overwrite,
  output logic                  frm_discard,
  output logic                  ring_halt
);
  logic [PG_W-1:0] start_pg, stop_pg, cur_pg, bnd_pg, cur_next;
  logic            cur_load;

  rx_ring_regs #(.PG_W(PG_W), .START_DEF(START_DEF), .STOP_DEF(STOP_DEF)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_load(cur_load), .cur_next(cur_next), .ovw_evt(frm_overwrite),
    .start_pg(start_pg), .stop_pg(stop_pg), .cur_pg(cur_pg), .bnd_pg(bnd_pg),
    .halt(ring_halt)
  );

  rx_ring_writer #(.PG_W(PG_W), .MIN_LEN(MIN_LEN)) wr_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_crc_err(in_crc_err),
    .in_align_err(in_align_err), .cfg_accept_runt(cfg_accept_runt),
    .cfg_save_errored(cfg_save_errored), .cfg_monitor(cfg_monitor),
    .start_pg(start_pg), .stop_pg(stop_pg), .cur_pg(cur_pg), .bnd_pg(bnd_pg),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_load(cur_load), .cur_next(cur_next), .done_ok(frm_stored),
    .frm_missed(frm_missed), .frm_ovw(frm_overwrite), .frm_discard(frm_discard)
  );

  AST_OVW_IS_MISSED: assert property (@(posedge clk) disable iff (rst)
    frm_overwrite |-> frm_missed);  // R4
endmodule

// File: tb/rx_page_ring_tb.sv
module rx_page_ring_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, in_valid, in_sof, in_eof, in_crc_err, in_align_err;
  logic cfg_accept_runt, cfg_save_errored, cfg_monitor, reg_we;
  logic [7:0] in_data, reg_wdata, reg_rdata, mem_wdata;
  logic [1:0] reg_addr;
  logic [15:0] mem_addr;
  logic mem_we, frm_stored, frm_missed, frm_overwrite, frm_discard, ring_halt;

  rx_page_ring dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_crc_err(in_crc_err),
    .in_align_err(in_align_err), .cfg_accept_runt(cfg_accept_runt),
    .cfg_save_errored(cfg_save_errored), .cfg_monitor(cfg_monitor),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .frm_stored(frm_stored), .frm_missed(frm_missed),
    .frm_overwrite(frm_overwrite), .frm_discard(frm_discard),
    .ring_halt(ring_halt)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_errors = 0;
  bit started = 0, finished = 0;
  int q_cyc[$], q_addr[$], q_data[$];
  string q_tag[$];
  int exp_stored_at = -1, exp_missed_at = -1, exp_ovw_at = -1, exp_disc_at = -1;
  string miss_tag = "R5", disc_tag = "R6";
  int m_start = 'h40, m_stop = 'h80, m_cur = 'h40, m_bnd = 'h7F, seed = 1;
  bit m_halt = 0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic int pinc(int p);
    return (p + 1 == m_stop) ? m_start : p + 1;
  endfunction

  task automatic push(int c, int a, int d, string t);
    q_cyc.push_back(c); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      if (mem_we) begin
        if (q_cyc.size() == 0)
          check(0, "R2 R5", "unexpected write addr", int'(mem_addr), 0);
        else begin
          check(q_cyc[0] == cyc, q_tag[0], "write cycle", cyc, q_cyc[0]);
          check(int'(mem_addr) == q_addr[0], q_tag[0], "write addr", int'(mem_addr), q_addr[0]);
          check(int'(mem_wdata) == q_data[0], q_tag[0], "write data", int'(mem_wdata), q_data[0]);
          void'(q_cyc.pop_front()); void'(q_addr.pop_front());
          void'(q_data.pop_front()); void'(q_tag.pop_front());
        end
      end else if (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
        check(0, q_tag[0], "missing write addr", 0, q_addr[0]);
        void'(q_cyc.pop_front()); void'(q_addr.pop_front());
        void'(q_data.pop_front()); void'(q_tag.pop_front());
      end
      if (frm_stored || cyc == exp_stored_at)
        check(frm_stored == (cyc == exp_stored_at), "R3", "stored pulse", frm_stored, cyc == exp_stored_at);
      if (frm_missed || cyc == exp_missed_at)
        check(frm_missed == (cyc == exp_missed_at), miss_tag, "missed pulse", frm_missed, cyc == exp_missed_at);
      if (frm_overwrite || cyc == exp_ovw_at)
        check(frm_overwrite == (cyc == exp_ovw_at), "R4", "overwrite pulse", frm_overwrite, cyc == exp_ovw_at);
      if (frm_discard || cyc == exp_disc_at)
        check(frm_discard == (cyc == exp_disc_at), disc_tag, "discard pulse", frm_discard, cyc == exp_disc_at);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 0;
    case (a)
      0: m_start = d;
      1: m_stop = d;
      2: m_cur = d;
      default: begin if (d != m_bnd) m_halt = 0; m_bnd = d; end
    endcase
  endtask

  task automatic rd(int a, int expv, string tag);
    @(negedge clk);
    reg_addr = 2'(a);
    #1;
    check(int'(reg_rdata) == expv, tag, "register read", int'(reg_rdata), expv);
  endtask

  task automatic send_frame(int n, bit crc, bit aln, bit mon, bit runt_ok, bit save_ok, string tag);
    int p, o, first, nxt, last, st;
    bit blk, ovf;
    p = m_cur; o = 4; first = m_cur; blk = 0; last = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_accept_runt = runt_ok; cfg_save_errored = save_ok; cfg_monitor = mon;
      in_valid = 1; in_data = 8'((seed + i) & 255);
      in_sof = (i == 0); in_eof = (i == n - 1);
      in_crc_err = crc; in_align_err = aln;
      if (!mon && !blk) push(cyc + 1, p * 256 + o, (seed + i) & 255, tag);
      o++;
      if (o == 256) begin o = 0; p = pinc(p); if (p == m_bnd) blk = 1; end
      if (i == n - 1) last = cyc + 1;
    end
    nxt = (o == 0) ? p : pinc(p);
    ovf = !mon && (blk || nxt == m_bnd);
    if (mon) begin
      exp_missed_at = last; miss_tag = "R5";
    end else if (ovf) begin
      exp_missed_at = last; exp_ovw_at = last; miss_tag = "R4"; m_halt = 1;
    end else if ((n < 64 && !runt_ok) || ((crc || aln) && !save_ok)) begin
      exp_disc_at = last; disc_tag = (n < 64 && !runt_ok) ? "R6" : "R7";
    end else begin
      st = (crc ? 2 : 0) | (aln ? 4 : 0) | ((crc || aln) ? 0 : 1);
      push(last + 1, first * 256 + 0, st, "R3");
      push(last + 2, first * 256 + 1, nxt, "R3");
      push(last + 3, first * 256 + 2, (n + 4) & 255, "R3");
      push(last + 4, first * 256 + 3, (n + 4) >> 8, "R3");
      exp_stored_at = last + 4;
      m_cur = nxt;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_crc_err = 0; in_align_err = 0;
    repeat (6) @(negedge clk);
    seed += n;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    rst = 1; in_valid = 0; in_data = 0; in_sof = 0; in_eof = 0;
    in_crc_err = 0; in_align_err = 0; cfg_accept_runt = 0;
    cfg_save_errored = 0; cfg_monitor = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    started = 1;
    // R10 reset values
    rd(0, 'h40, "R10"); rd(1, 'h80, "R10"); rd(2, 'h40, "R10"); rd(3, 'h7F, "R10");
    check(ring_halt == 0, "R8", "halt after reset", ring_halt, 0);
    check(mem_we == 0, "R2", "no write after reset", mem_we, 0);
    // small four-page ring 0x40..0x43
    wr(1, 'h44); wr(3, 'h43);
    rd(1, 'h44, "R10"); rd(3, 'h43, "R10");
    send_frame(100, 0, 0, 0, 0, 0, "R2");
    rd(2, 'h41, "R3");
    wr(3, 'h40);
    send_frame(300, 0, 0, 0, 0, 0, "R2");
    rd(2, 'h43, "R3");
    wr(3, 'h42);
    send_frame(20, 0, 0, 0, 0, 0, "R6");        // runt, dropped
    rd(2, 'h43, "R9");
    send_frame(20, 0, 0, 0, 1, 0, "R6");        // runt, kept; next page wraps
    rd(2, 'h40, "R1");
    send_frame(80, 1, 0, 0, 0, 0, "R7");        // CRC error, dropped
    rd(2, 'h40, "R9");
    send_frame(80, 1, 0, 0, 0, 1, "R7");        // CRC error, kept
    rd(2, 'h41, "R7");
    send_frame(600, 0, 0, 0, 0, 0, "R4");       // runs into boundary
    rd(2, 'h41, "R9");
    check(ring_halt == m_halt, "R8", "halt after overrun", ring_halt, m_halt);
    wr(3, 'h42);
    check(ring_halt == m_halt, "R8", "halt after same boundary", ring_halt, m_halt);
    wr(3, 'h40);
    check(ring_halt == m_halt, "R8", "halt after boundary moved", ring_halt, m_halt);
    send_frame(100, 0, 0, 1, 0, 0, "R5");       // monitor mode
    rd(2, 'h41, "R5");
    send_frame(500, 0, 0, 0, 0, 0, "R2");
    rd(2, 'h43, "R3");
    wr(3, 'h42);
    send_frame(300, 0, 0, 0, 0, 0, "R1");       // data wraps end page to first
    rd(2, 'h41, "R1");
    check(q_cyc.size() == 0, "R3", "writes left pending", q_cyc.size(), 0);
    finish_run();
  end
endmodule